// File: doc/BRIEF.md
# Interlaced Video Capture Framebuffer Writer

This block sits between a digital video decoder and a shared memory bus. It takes an 8-bit 4:2:2 colour-difference byte stream, clocked by the pixel clock, in which the timing is carried as embedded reference codes rather than separate sync wires. It decodes those codes to find the active part of each line and the field identity. It keeps only active lines of the odd field and packs every group of four bytes into one 32-bit word. Each word is written to a framebuffer in external memory through a request/grant/acknowledge bus that runs on its own clock.

Capture runs freely and is not aligned to frame starts. The write address climbs through one field's worth of words, then wraps to the framebuffer base and carries on. A static scene is therefore rewritten over itself again and again. A single enable input gates capture line by line.

The word and its ready indication cross into the bus domain through a toggle handshake. The bus request is the exclusive-or of a video-domain toggle and a bus-domain completion toggle. As a result the request rises on the video clock edge that finishes a word, so arbitration can start before the bus side has synchronised anything, and it falls only on a bus clock edge. If a finished word meets a transfer that is still outstanding, the word is discarded and a saturating drop counter advances.

Top module: `vid_fb_writer`

## Requirements
- R1: A timing code is the byte sequence FF, 00, 00 followed by a status byte. In the status byte, bit 6 is the field flag (0 = odd field), bit 5 is vertical blanking and bit 4 is horizontal blanking. A status byte with bits 6, 5 and 4 all zero opens a capture window of exactly WORDS_PER_LINE×4 bytes, starting with the byte after the status byte.
- R2: A line whose opening status byte has the field flag set (even field) or the vertical blanking flag set produces no bus write.
- R3: Four captured bytes in arrival order form one word, the first byte in bits 31:24 and the fourth in bits 7:0.
- R4: The k-th write of the run goes to BASE_ADDR + 4×(k mod (LINES×WORDS_PER_LINE)), so the address steps by 4 and wraps to the base after one field's worth of words.
- R5: `capture_en` is sampled when a line opens. A line opened while it is 0 produces no write and no drop.
- R6: `bus_req` rises on the video clock edge that completes a word, without waiting for a bus clock edge.
- R7: After the last pending word is acknowledged, `bus_req` falls on the bus clock edge that samples `bus_ack`.
- R8: `bus_sel` rises only on a bus clock edge that samples `bus_gnt` high while a word is pending. `bus_addr` and `bus_data` then stay stable until the edge that samples `bus_ack`, and each word is written exactly once.
- R9: A word completed while the previous word is still unacknowledged is discarded and `ovf_count` increments by one (saturating). The held word is still written.
- R10: After reset, `bus_req`, `bus_sel` and `ovf_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vid_clk | input | 1 | Pixel byte clock |
| vid_rst | input | 1 | Synchronous active-high reset, video domain |
| vid_byte | input | 8 | Video byte stream with embedded timing codes |
| capture_en | input | 1 | Capture enable, sampled at each line opening |
| bus_clk | input | 1 | Memory bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_ack | input | 1 | Write acknowledge from memory slave |
| bus_req | output | 1 | Bus request, rises on video edge and falls on bus edge |
| bus_sel | output | 1 | Master select, marks an active write |
| bus_addr | output | ADDR_W | Write byte address |
| bus_data | output | DATA_W | Write data |
| ovf_count | output | OVF_W | Count of words dropped because the bus was busy |

## Verification
The bench targets the timing-code parser first. Even-field and vertical-blanking lines must leave the bus silent, and a parser that ignored bits 6 or 5 would produce extra writes, which the scoreboard rejects as unexpected. The bench measures the exact instant the request rises and falls against the two clock grids. A request registered in the bus domain would rise on a bus edge, and one that fell combinationally would fall off the bus grid. The bench runs more than one field's worth of words so that the address must wrap, and an off-by-one in the wrap limit shows up as a wrong address. With the grant withheld for a whole line, exactly one word must survive and the drop counter must show the rest. A design that overwrote the held word, or counted the held word as a drop, would give the wrong data or the wrong count.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
  localparam logic [7:0] PRE_HI = 8'hFF;
  localparam logic [7:0] PRE_LO = 8'h00;
  localparam int ST_FIELD = 6;
  localparam int ST_VBLK  = 5;
  localparam int ST_HBLK  = 4;

  typedef enum logic {
    BM_IDLE = 1'b0,
    BM_XFER = 1'b1
  } bm_state_t;
endpackage

// File: rtl/vfw_sync.sv
module vfw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/vfw_code_decode.sv
module vfw_code_decode
  import vfw_pkg::*;
#(
  parameter int BYTES_PER_LINE = 1440
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [7:0] byte_i,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  localparam int CW = $clog2(BYTES_PER_LINE);

  logic [7:0]    h1, h2, h3;
  logic          active;
  logic [CW-1:0] cnt;
  logic          hdr;

  // the current byte is a status byte when the three before it form the preamble
  assign hdr = (h3 == PRE_HI) && (h2 == PRE_LO) && (h1 == PRE_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      h1       <= '0;
      h2       <= '0;
      h3       <= '0;
      active   <= 1'b0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      h1       <= byte_i;
      h2       <= h1;
      h3       <= h2;
      byte_vld <= 1'b0;
      if (hdr) begin
        active <= en && !byte_i[ST_FIELD] && !byte_i[ST_VBLK] && !byte_i[ST_HBLK];
        cnt    <= '0;
      end else if (active) begin
        byte_vld <= 1'b1;
        byte_q   <= byte_i;
        cnt      <= cnt + 1'b1;
        if (cnt == CW'(BYTES_PER_LINE - 1)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vfw_packer.sv
module vfw_packer #(
  parameter int DATA_W = 32,
  parameter int OVF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_d,
  input  logic              done_tgl_s,
  output logic              req_tgl,
  output logic [DATA_W-1:0] word_q,
  output logic [OVF_W-1:0]  ovf_cnt
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] full;
  logic [LW-1:0]     lane;
  logic              busy;

  assign full = {acc[DATA_W-9:0], byte_d};
  assign busy = (req_tgl != done_tgl_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      lane    <= '0;
      req_tgl <= 1'b0;
      word_q  <= '0;
      ovf_cnt <= '0;
    end else if (byte_vld) begin
      acc  <= full;
      lane <= lane + 1'b1;
      if (lane == LW'(LANES - 1)) begin
        if (!busy) begin
          word_q  <= full;
          req_tgl <= ~req_tgl;
        end else if (ovf_cnt != {OVF_W{1'b1}}) begin
          ovf_cnt <= ovf_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vfw_bus_master.sv
module vfw_bus_master
  import vfw_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter int               DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8010_5000,
  parameter int               TOTAL     = 94680
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl_raw,
  input  logic              req_tgl_s,
  input  logic [DATA_W-1:0] word_d,
  input  logic              gnt,
  input  logic              ack,
  output logic              req,
  output logic              sel,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              seen_tgl
);
  localparam int IW = $clog2(TOTAL);

  bm_state_t     st;
  logic [IW-1:0] idx;

  // rises with the video-domain toggle, falls only when seen_tgl flips here
  assign req = req_tgl_raw ^ seen_tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BM_IDLE;
      idx      <= '0;
      sel      <= 1'b0;
      addr     <= '0;
      data     <= '0;
      seen_tgl <= 1'b0;
    end else begin
      case (st)
        BM_IDLE: begin
          if ((req_tgl_s != seen_tgl) && gnt) begin
            sel  <= 1'b1;
            addr <= BASE_ADDR + (ADDR_W'(idx) << 2);
            data <= word_d;
            st   <= BM_XFER;
          end
        end
        BM_XFER: begin
          if (ack) begin
            sel      <= 1'b0;
            seen_tgl <= ~seen_tgl;
            idx      <= (idx == IW'(TOTAL - 1)) ? '0 : idx + 1'b1;
            st       <= BM_IDLE;
          end
        end
        default: st <= BM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vid_fb_writer.sv
module vid_fb_writer #(
  parameter int                ADDR_W         = 32,
  parameter int                DATA_W         = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 32'h8010_5000,
  parameter int                LINES          = 263,
  parameter int                WORDS_PER_LINE = 360,
  parameter int                OVF_W          = 16,
  parameter int                SYNC_STAGES    = 2
) (
  input  logic              vid_clk,
  input  logic              vid_rst,
  input  logic [7:0]        vid_byte,
  input  logic              capture_en,
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int BYTES_PER_LINE = WORDS_PER_LINE * (DATA_W / 8);
  localparam int TOTAL          = LINES * WORDS_PER_LINE;

  logic              en_s;
  logic              byte_vld;
  logic [7:0]        byte_q;
  logic              req_tgl;
  logic              req_tgl_s;
  logic              seen_tgl;
  logic              seen_s;
  logic [DATA_W-1:0] word_q;

  vfw_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(vid_clk), .rst(vid_rst), .d(capture_en), .q(en_s)
  );

  vfw_code_decode #(.BYTES_PER_LINE(BYTES_PER_LINE)) u_dec (
    .clk(vid_clk), .rst(vid_rst), .en(en_s), .byte_i(vid_byte),
    .byte_vld(byte_vld), .byte_q(byte_q)
  );

  vfw_packer #(.DATA_W(DATA_W), .OVF_W(OVF_W)) u_pack (
    .clk(vid_clk), .rst(vid_rst), .byte_vld(byte_vld), .byte_d(byte_q),
    .done_tgl_s(seen_s), .req_tgl(req_tgl), .word_q(word_q), .ovf_cnt(ovf_count)
  );

  vfw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(bus_clk), .rst(bus_rst), .d(req_tgl), .q(req_tgl_s)
  );

  vfw_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(vid_clk), .rst(vid_rst), .d(seen_tgl), .q(seen_s)
  );

  vfw_bus_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .TOTAL(TOTAL)
  ) u_bm (
    .clk(bus_clk), .rst(bus_rst), .req_tgl_raw(req_tgl), .req_tgl_s(req_tgl_s),
    .word_d(word_q), .gnt(bus_gnt), .ack(bus_ack), .req(bus_req),
    .sel(bus_sel), .addr(bus_addr), .data(bus_data), .seen_tgl(seen_tgl)
  );
endmodule

// File: rtl/vfw_checker.sv
module vfw_checker #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8010_5000,
  parameter int                TOTAL     = 94680,
  parameter int                OVF_W     = 16
) (
  input logic              vid_clk,
  input logic              vid_rst,
  input logic              bus_clk,
  input logic              bus_rst,
  input logic              bus_gnt,
  input logic              bus_ack,
  input logic              bus_req,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic [OVF_W-1:0]  ovf_count
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(4 * (TOTAL - 1));

  logic [ADDR_W-1:0] exp_next;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) exp_next <= BASE_ADDR;
    else if (bus_sel && bus_ack)
      exp_next <= (bus_addr == LAST_ADDR) ? BASE_ADDR : bus_addr + ADDR_W'(4);
  end

  AST_SEL_AFTER_GNT: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(bus_sel) |-> $past(bus_gnt)); // R8
  AST_SEL_HOLD: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_sel && !bus_ack) |=> (bus_sel && $stable(bus_addr) && $stable(bus_data))); // R8
  AST_SEL_HAS_REQ: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_sel |-> bus_req); // R8
  AST_ADDR_SEQ: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(bus_sel) |-> (bus_addr == exp_next)); // R4
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $fell(bus_req) |-> $past(bus_ack)); // R7
  AST_OVF_STEP: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !$stable(ovf_count) |-> (ovf_count == $past(ovf_count) + 1'b1)); // R9
endmodule

bind vid_fb_writer vfw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
  .TOTAL(LINES * WORDS_PER_LINE), .OVF_W(OVF_W)
) u_chk (
  .vid_clk(vid_clk), .vid_rst(vid_rst), .bus_clk(bus_clk), .bus_rst(bus_rst),
  .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_req(bus_req), .bus_sel(bus_sel),
  .bus_addr(bus_addr), .bus_data(bus_data), .ovf_count(ovf_count)
);

// File: tb/sim_vid_fb_writer.sv
module sim_vid_fb_writer;
  localparam logic [31:0] BASE = 32'h8010_5000;
  localparam int LINES = 3;
  localparam int WPL   = 8;
  localparam int TOTAL = LINES * WPL;
  localparam int OVF_W = 8;

  logic bus_clk = 1'b0;
  logic vid_clk = 1'b0;
  logic vid_rst = 1'b1;
  logic bus_rst = 1'b1;
  logic [7:0] vid_byte = 8'h10;
  logic capture_en = 1'b0;
  logic allow = 1'b0;
  logic bus_ack = 1'b0;
  logic bus_gnt;
  logic bus_req, bus_sel;
  logic [31:0] bus_addr, bus_data;
  logic [OVF_W-1:0] ovf_count;

  logic [63:0] expq[$];
  int n_chk = 0;
  int n_fail = 0;
  int exp_idx = 0;
  int n_wr = 0;
  int n_push = 0;
  int dly = 0;
  time t_rise = 0;
  time t_fall = 0;

  always #5 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever #40 vid_clk = ~vid_clk;
  end

  assign bus_gnt = allow & bus_req;

  vid_fb_writer #(
    .BASE_ADDR(BASE), .LINES(LINES), .WORDS_PER_LINE(WPL), .OVF_W(OVF_W)
  ) u0 (
    .vid_clk(vid_clk), .vid_rst(vid_rst), .vid_byte(vid_byte), .capture_en(capture_en),
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_gnt(bus_gnt), .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_data(bus_data),
    .ovf_count(ovf_count)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge vid_clk);
    vid_byte = b;
  endtask

  // status: timing code byte; keep: words to expect (-1 = all)
  task automatic send_line(input logic [7:0] status, input int seed, input int keep);
    logic [7:0] bq[4];
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(status);
    for (int w = 0; w < WPL; w++) begin
      for (int k = 0; k < 4; k++) begin
        bq[k] = 8'(1 + ((seed + w * 4 + k) % 250));
        send_byte(bq[k]);
      end
      if (status == 8'h80 && capture_en && (keep < 0 || w < keep)) begin
        expq.push_back({BASE + 32'(4 * exp_idx), bq[0], bq[1], bq[2], bq[3]});
        exp_idx = (exp_idx + 1) % TOTAL;
        n_push++;
      end
    end
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h9D);
    for (int i = 0; i < 8; i++) send_byte((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && expq.size() != 0; i++) @(negedge bus_clk);
    repeat (60) @(negedge bus_clk);
  endtask

  // slave and scoreboard monitor
  initial begin
    logic [63:0] e;
    forever begin
      @(negedge bus_clk);
      if (bus_sel && !bus_ack) begin
        for (int i = 0; i < dly; i++) @(negedge bus_clk);
        n_wr++;
        if (expq.size() == 0) begin
          check_eq("R2/R5 unexpected write", {bus_addr, bus_data}, 64'h0);
        end else begin
          e = expq.pop_front();
          check_eq("R4 write address", {32'h0, bus_addr}, {32'h0, e[63:32]});
          check_eq("R3 write data", {32'h0, bus_data}, {32'h0, e[31:0]});
        end
        bus_ack = 1'b1;
        @(negedge bus_clk);
        bus_ack = 1'b0;
        dly = (dly + 1) % 4;
      end
    end
  end

  initial begin
    #500us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge vid_clk);
    vid_rst = 1'b0;
    bus_rst = 1'b0;
    @(negedge vid_clk);
    // R10 reset state
    check_eq("R10 bus_req after reset", {63'h0, bus_req}, 64'h0);
    check_eq("R10 bus_sel after reset", {63'h0, bus_sel}, 64'h0);
    check_eq("R10 ovf_count after reset", 64'(ovf_count), 64'h0);

    allow = 1'b1;
    capture_en = 1'b1;
    repeat (4) @(negedge vid_clk);

    // R1 odd active line captured in full
    send_line(8'h80, 0, -1);
    drain();
    check_eq("R1 writes after first odd line", 64'(n_wr), 64'(WPL));

    // R2 even field and vertical blanking lines ignored
    send_line(8'hC0, 11, -1);
    send_line(8'hA0, 23, -1);
    drain();
    check_eq("R2 writes after even/vblank lines", 64'(n_wr), 64'(WPL));

    send_line(8'h80, 37, -1);
    drain();

    // R5 disabled line ignored
    capture_en = 1'b0;
    repeat (4) @(negedge vid_clk);
    send_line(8'h80, 59, -1);
    drain();
    check_eq("R5 writes after disabled line", 64'(n_wr), 64'(2 * WPL));
    check_eq("R5 no drop while disabled", 64'(ovf_count), 64'h0);

    // R4 wrap: third and fourth enabled lines cross the field limit
    capture_en = 1'b1;
    repeat (4) @(negedge vid_clk);
    send_line(8'h80, 71, -1);
    send_line(8'h80, 97, -1);
    drain();
    check_eq("R4 writes after wrap", 64'(n_wr), 64'(n_push));
    check_eq("R9 no drop with fast slave", 64'(ovf_count), 64'h0);

    // R9 overflow: grant withheld for a full line
    allow = 1'b0;
    fork
      begin @(posedge bus_req); t_rise = $time; end
    join_none
    send_line(8'h80, 131, 1);
    repeat (4) @(negedge vid_clk);
    check_eq("R9 dropped word count", 64'(ovf_count), 64'(WPL - 1));
    check_eq("R6 request pending without grant", {63'h0, bus_req}, 64'h1);
    check_eq("R6 request rose off bus edge", 64'(t_rise % 10 == 5), 64'h0);
    check_eq("R6 request rose on video edge", 64'(t_rise % 80), 64'd43);
    fork
      begin @(negedge bus_req); t_fall = $time; end
    join_none
    @(negedge bus_clk);
    allow = 1'b1;
    drain();
    check_eq("R7 request fell on bus edge", 64'(t_fall % 10), 64'd5);
    check_eq("R7 request low after ack", {63'h0, bus_req}, 64'h0);
    check_eq("R8 every word written once", 64'(n_wr), 64'(n_push));
    check_eq("R8 scoreboard drained", 64'(expq.size()), 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule